// File: doc/BRIEF.md
# Quadrature Encoder Position Register

This block turns the two phase outputs of an incremental shaft encoder into a signed position count. Software reads that count as one 32-bit word over a simple register bus that uses chip enables. Both encoder channels are asynchronous to the bus clock, so each one passes through a synchroniser chain before any logic looks at it. The count moves by one step on every rising transition of channel A. The level of channel B at that moment sets the direction, and the count is held between a fixed negative and positive limit.

The bus selects registers with one-hot chip-enable bits. Enable bit 0 selects the position word at byte offset 0x0 and enable bit 1 selects a control word at offset 0x4. The bus numbers its bits with bit 0 as the most significant bit. The position word is a two's-complement value sign-extended over the full width, so a signed integer read in software returns negative positions correctly. Writing a one into the least significant bit of the control word sets the count back to zero.

Top module: `qenc_pos_reg`

## Requirements
- R1: After reset the count is zero, the control word reads zero, and the synchronisers are cleared.
- R2: A rising transition of channel A while channel B is low increases the count by one.
- R3: A rising transition of channel A while channel B is high decreases the count by one.
- R4: A falling transition of channel A and any change of channel B while A is steady leave the count unchanged.
- R5: The count never exceeds +5000. A step upward at +5000 is ignored.
- R6: The count never goes below -5000. A step downward at -5000 is ignored.
- R7: The position word is the count in 32-bit two's complement, sign-extended. Bus bit 0 is the MSB, so the sign is in bit 0 (for example, -3 reads as 0xFFFFFFFD).
- R8: Read enable bit 0 returns the position word and bit 1 returns the control word. With no read enable asserted, read data is all zeros.
- R9: The read acknowledge is high exactly when a read enable is high, and the write acknowledge is high exactly when a write enable is high. The error response is always low.
- R10: A write to the control word (write enable bit 1) updates only the byte lanes whose byte enable is set. Byte enable bit 0 covers bus bits 0 to 7 (the most significant byte), and the stored word reads back.
- R11: A control write with byte enable bit 3 set and data bit 31 (the LSB) equal to one clears the count at the clock edge that ends the write. Without that byte enable, no clear happens.
- R12: A write to the position word (write enable bit 0) leaves the count unchanged.
- R13: A count step becomes visible on the third rising clock edge after channel A goes high, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| rd_ce | input | NUM_REGS | One-hot read chip enables, bit 0 = offset 0x0 |
| wr_ce | input | NUM_REGS | One-hot write chip enables |
| be | input | DATA_W/8 | Byte enables, bit 0 = most significant byte |
| wdata | input | DATA_W | Write data, bit 0 = MSB |
| rd_data | output | DATA_W | Read data, bit 0 = MSB |
| rd_ack | output | 1 | Read acknowledge |
| wr_ack | output | 1 | Write acknowledge |
| err | output | 1 | Error response, always low |

## Verification
An edge on channel A goes through two synchroniser flops and then the counter register. Its step therefore appears on the third clock edge after A rises. The bench samples at the negedges after the second and third edges to confirm that the old value is held and then the new value appears. A control write clears the count at the single clock edge inside the write cycle, so the bench reads the position at the following negedge. Read data and both acknowledges come straight from the enables and are sampled a short delay after the enables change, within the same cycle. Random steps are spaced six cycles apart so each step settles before the next one, and every read compares against a bench model of the saturating count.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   // register indices on the chip-enable vectors (index i = byte offset 4*i)
   localparam int unsigned REG_POS  = 0;
   localparam int unsigned REG_CTRL = 1;

   // signed width able to hold +/-limit
   function automatic int unsigned count_width(input int unsigned limit);
      return $clog2(limit + 1) + 1;
   endfunction

   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_UP   = 2'b01,
      STEP_DOWN = 2'b10
   } step_e;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] stage_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage_q[0] <= 1'b0;
            else     stage_q[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= 1'b0;
            else     stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qenc_stepper.sv
module qenc_stepper
   import qenc_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  a_sync,
   input  logic  b_sync,
   output step_e step
);
   logic a_last_q;
   logic a_rise;

   always_ff @(posedge clk) begin
      if (rst) a_last_q <= 1'b0;
      else     a_last_q <= a_sync;
   end

   assign a_rise = a_sync & ~a_last_q;

   always_comb begin
      if (!a_rise)     step = STEP_HOLD;
      else if (b_sync) step = STEP_DOWN;
      else             step = STEP_UP;
   end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
   import qenc_pkg::*;
#(
   parameter int unsigned LIMIT = 5000,
   parameter int unsigned CNT_W = 14
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  step_e                   step,
   output logic signed [CNT_W-1:0] count
);
   localparam logic signed [CNT_W-1:0] TOP_C = CNT_W'(LIMIT);
   localparam logic signed [CNT_W-1:0] BOT_C = -TOP_C;
   localparam logic signed [CNT_W-1:0] ONE_C = CNT_W'(1);

   logic signed [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         count_q <= '0;
      end else begin
         unique case (step)
            STEP_UP:   if (count_q != TOP_C) count_q <= count_q + ONE_C;
            STEP_DOWN: if (count_q != BOT_C) count_q <= count_q - ONE_C;
            default:   count_q <= count_q;
         endcase
      end
   end

   assign count = count_q;
endmodule

// File: rtl/qenc_regbus.sv
module qenc_regbus
   import qenc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 2,
   parameter int unsigned CNT_W    = 14
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [0:NUM_REGS-1]     rd_ce,
   input  logic [0:NUM_REGS-1]     wr_ce,
   input  logic [0:DATA_W/8-1]     be,
   input  logic [0:DATA_W-1]       wdata,
   input  logic signed [CNT_W-1:0] count,
   output logic [0:DATA_W-1]       rd_data,
   output logic                    rd_ack,
   output logic                    wr_ack,
   output logic                    err,
   output logic                    clr_req
);
   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned EXT_W = DATA_W - CNT_W;

   logic [0:DATA_W-1] reg_word [NUM_REGS];
   logic [0:DATA_W-1] ctrl_word;

   // control word: one register per byte lane
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [0:7] lane_q;
      always_ff @(posedge clk) begin
         if (rst)
            lane_q <= '0;
         else if (wr_ce[REG_CTRL] && be[k])
            lane_q <= wdata[k*8 +: 8];
      end
      assign ctrl_word[k*8 +: 8] = lane_q;
   end

   // register words in chip-enable order
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      if (i == REG_POS) begin : g_pos
         assign reg_word[i] = {{EXT_W{count[CNT_W-1]}}, count};
      end else if (i == REG_CTRL) begin : g_ctrl
         assign reg_word[i] = ctrl_word;
      end else begin : g_unused
         assign reg_word[i] = '0;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_ce[i]) rd_data = rd_data | reg_word[i];
      end
   end

   assign clr_req = wr_ce[REG_CTRL] & be[LANES-1] & wdata[DATA_W-1];
   assign rd_ack  = |rd_ce;
   assign wr_ack  = |wr_ce;
   assign err     = 1'b0;
endmodule

// File: rtl/qenc_pos_reg.sv
module qenc_pos_reg
   import qenc_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_REGS    = 2,
   parameter int unsigned LIMIT       = 5000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  enc_a,
   input  logic                  enc_b,
   input  logic [0:NUM_REGS-1]   rd_ce,
   input  logic [0:NUM_REGS-1]   wr_ce,
   input  logic [0:DATA_W/8-1]   be,
   input  logic [0:DATA_W-1]     wdata,
   output logic [0:DATA_W-1]     rd_data,
   output logic                  rd_ack,
   output logic                  wr_ack,
   output logic                  err
);
   localparam int unsigned CNT_W  = count_width(LIMIT);
   localparam int unsigned N_CHAN = 2;

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("qenc_pos_reg: DATA_W must be a multiple of 8");
   end
   if (CNT_W >= DATA_W) begin : g_bad_limit
      $error("qenc_pos_reg: LIMIT too large for DATA_W");
   end
   if (NUM_REGS < 2) begin : g_bad_regs
      $error("qenc_pos_reg: NUM_REGS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("qenc_pos_reg: SYNC_STAGES must be at least 2");
   end

   logic [N_CHAN-1:0]       chan_raw;
   logic [N_CHAN-1:0]       chan_sync;
   step_e                   step_w;
   logic                    clr_w;
   logic signed [CNT_W-1:0] count_w;

   assign chan_raw = {enc_a, enc_b};

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      qenc_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst  (rst),
         .din  (chan_raw[c]),
         .dout (chan_sync[c])
      );
   end

   qenc_stepper u_stepper (
      .clk    (clk),
      .rst    (rst),
      .a_sync (chan_sync[1]),
      .b_sync (chan_sync[0]),
      .step   (step_w)
   );

   qenc_counter #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_counter (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr_w),
      .step  (step_w),
      .count (count_w)
   );

   qenc_regbus #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_regbus (
      .clk     (clk),
      .rst     (rst),
      .rd_ce   (rd_ce),
      .wr_ce   (wr_ce),
      .be      (be),
      .wdata   (wdata),
      .count   (count_w),
      .rd_data (rd_data),
      .rd_ack  (rd_ack),
      .wr_ack  (wr_ack),
      .err     (err),
      .clr_req (clr_w)
   );
endmodule

// File: rtl/qenc_pos_reg_chk.sv
module qenc_pos_reg_chk
   import qenc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 2,
   parameter int unsigned LIMIT    = 5000,
   parameter int unsigned CNT_W    = 14
) (
   input logic                    clk,
   input logic                    rst,
   input logic [0:NUM_REGS-1]     rd_ce,
   input logic [0:NUM_REGS-1]     wr_ce,
   input logic [0:DATA_W-1]       rd_data,
   input logic                    rd_ack,
   input logic                    wr_ack,
   input logic [1:0]              step,
   input logic                    clr,
   input logic signed [CNT_W-1:0] count
);
   localparam logic signed [CNT_W-1:0] TOP_C = CNT_W'(LIMIT);
   localparam logic signed [CNT_W-1:0] BOT_C = -TOP_C;
   localparam logic signed [CNT_W-1:0] ONE_C = CNT_W'(1);

   assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
      (step == 2'(STEP_UP) && !clr && count != TOP_C) |=> count == $past(count) + ONE_C);

   assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
      (step == 2'(STEP_DOWN) && !clr && count != BOT_C) |=> count == $past(count) - ONE_C);

   assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (step == 2'(STEP_HOLD) && !clr) |=> $stable(count));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      count <= TOP_C);

   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
      count >= BOT_C);

   assert_sign_msb_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_ce[REG_POS] && $countones(rd_ce) == 1) |-> rd_data[0] == count[CNT_W-1]);

   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (rd_ce == '0) |-> rd_data == '0);

   assert_acks_R9: assert property (@(posedge clk) disable iff (rst)
      (rd_ack == (rd_ce != '0)) && (wr_ack == (wr_ce != '0)));

   assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
      clr |=> count == '0);
endmodule

bind qenc_pos_reg qenc_pos_reg_chk #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .LIMIT(LIMIT), .CNT_W(CNT_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .rd_ce   (rd_ce),
   .wr_ce   (wr_ce),
   .rd_data (rd_data),
   .rd_ack  (rd_ack),
   .wr_ack  (wr_ack),
   .step    (step_w),
   .clr     (clr_w),
   .count   (count_w)
);

// File: tb/tb_qenc_pos_reg.sv
`timescale 1ns/1ps
module tb_qenc_pos_reg;
   localparam int LIM = 5000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        enc_a = 1'b0;
   logic        enc_b = 1'b0;
   logic [0:1]  rd_ce = '0;
   logic [0:1]  wr_ce = '0;
   logic [0:3]  be = '0;
   logic [0:31] wdata = '0;
   logic [0:31] rd_data;
   logic        rd_ack, wr_ack, err;

   int n_total = 0;
   int n_pass  = 0;
   int model_pos = 0;
   logic [31:0] model_ctrl = '0;

   always #4 clk = ~clk;

   qenc_pos_reg dut (
      .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
      .rd_ce(rd_ce), .wr_ce(wr_ce), .be(be), .wdata(wdata),
      .rd_data(rd_data), .rd_ack(rd_ack), .wr_ack(wr_ack), .err(err)
   );

   function automatic int next_pos(input int p, input bit b);
      if (b) return (p > -LIM) ? p - 1 : p;
      else   return (p <  LIM) ? p + 1 : p;
   endfunction

   function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  lanes);
      logic [31:0] r = old_w;
      // lanes[3] is byte enable bit 0 = most significant byte
      for (int k = 0; k < 4; k++)
         if (lanes[3-k]) r[31-8*k -: 8] = new_w[31-8*k -: 8];
      return r;
   endfunction

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act === exp) n_pass++;
      else $display("FAIL %s actual=%h expected=%h", req, act, exp);
   endtask

   task automatic read_reg(input int idx, output logic [31:0] d, output logic ack);
      @(negedge clk);
      rd_ce = '0;
      rd_ce[idx] = 1'b1;
      #2;
      d = rd_data;
      ack = rd_ack;
      @(negedge clk);
      rd_ce = '0;
   endtask

   task automatic write_reg(input int idx, input logic [31:0] d, input logic [3:0] lanes,
                            output logic ack);
      @(negedge clk);
      wr_ce = '0;
      wr_ce[idx] = 1'b1;
      wdata = d;
      be = lanes;
      #2;
      ack = wr_ack;
      @(negedge clk);
      wr_ce = '0;
      be = '0;
      if (idx == 1) begin
         model_ctrl = merge_lanes(model_ctrl, d, lanes);
         if (lanes[0] && d[0]) model_pos = 0;
      end
   endtask

   task automatic pulse(input bit b);
      @(negedge clk);
      enc_b = b;
      @(negedge clk);
      enc_a = 1'b1;
      repeat (3) @(negedge clk);
      enc_a = 1'b0;
      @(negedge clk);
      model_pos = next_pos(model_pos, b);
   endtask

   task automatic check_pos(input string req);
      logic [31:0] d;
      logic ack;
      read_reg(0, d, ack);
      check_eq(req, d, 32'(model_pos));
   endtask

   initial begin
      #(190000 * 8);
      n_total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic ack;
      void'($urandom(32'd20091013));

      repeat (5) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      read_reg(0, d, ack);
      check_eq("R1 position after reset", d, 32'h0);
      read_reg(1, d, ack);
      check_eq("R1 control after reset", d, 32'h0);

      // R8 idle read data / R9 acks idle
      @(negedge clk); #2;
      check_eq("R8 idle read data", rd_data, 32'h0);
      check_eq("R9 idle acks and error", {29'b0, rd_ack, wr_ack, err}, 32'h0);

      // R2 increments
      pulse(1'b0); pulse(1'b0); pulse(1'b0);
      check_pos("R2 up count");
      // R3 decrements to negative, R7 sign extension
      repeat (6) pulse(1'b1);
      read_reg(0, d, ack);
      check_eq("R7 -3 sign extended", d, 32'hFFFF_FFFD);
      check_eq("R3 down count", d, 32'(model_pos));
      check_eq("R9 read ack", {31'b0, ack}, 32'h1);

      // R4 B toggles with A steady low and high, A falls
      repeat (4) begin @(negedge clk); enc_b = ~enc_b; end
      @(negedge clk); enc_a = 1'b1;
      repeat (4) @(negedge clk);
      model_pos = next_pos(model_pos, enc_b);
      repeat (4) begin @(negedge clk); enc_b = ~enc_b; end
      @(negedge clk); enc_a = 1'b0;
      repeat (4) @(negedge clk);
      check_pos("R4 only A rise steps");

      // R13 latency: step lands on third edge after A rises
      @(negedge clk); enc_b = 1'b0; rd_ce = 2'b10;
      @(negedge clk); enc_a = 1'b1;
      @(negedge clk); @(negedge clk); #2;
      check_eq("R13 unchanged after two edges", rd_data, 32'(model_pos));
      model_pos = next_pos(model_pos, 1'b0);
      @(negedge clk); #2;
      check_eq("R13 stepped on third edge", rd_data, 32'(model_pos));
      rd_ce = '0;
      @(negedge clk); enc_a = 1'b0;
      repeat (3) @(negedge clk);

      // R12 write to position ignored, R9 write ack
      write_reg(0, 32'h1234_5678, 4'b1111, ack);
      check_eq("R9 write ack", {31'b0, ack}, 32'h1);
      check_pos("R12 position write ignored");

      // R10 byte lanes
      write_reg(1, 32'hA1B2_C3D4, 4'b1010, ack);
      read_reg(1, d, ack);
      check_eq("R10 lanes 0 and 2", d, 32'hA100_C300);
      write_reg(1, 32'h1122_3344, 4'b0100, ack);
      read_reg(1, d, ack);
      check_eq("R10 lane 1", d, model_ctrl);

      // R11 clear without lane 3 enable: no clear
      write_reg(1, 32'hFFFF_FFFF, 4'b1110, ack);
      check_pos("R11 no clear without lane 3");
      // R11 clear
      write_reg(1, 32'h0000_0001, 4'b0001, ack);
      check_pos("R11 clear to zero");
      check_eq("R11 model zero", 32'(model_pos), 32'h0);
      read_reg(1, d, ack);
      check_eq("R10 control readback", d, model_ctrl);

      // random stimulus
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 49) == 0)
            write_reg(1, 32'h0000_0001, 4'b0001, ack);
         else
            pulse(1'($urandom_range(0, 1)));
         if (i % 25 == 24) check_pos("R2 R3 random walk");
      end

      // R5 saturation high
      write_reg(1, 32'h0000_0001, 4'b0001, ack);
      repeat (LIM + 3) pulse(1'b0);
      check_pos("R5 saturate high");
      check_eq("R5 value", 32'(model_pos), 32'd5000);
      pulse(1'b1);
      check_pos("R5 step back from limit");

      // R6 saturation low
      write_reg(1, 32'h0000_0001, 4'b0001, ack);
      repeat (LIM + 3) pulse(1'b1);
      read_reg(0, d, ack);
      check_eq("R6 saturate low", d, 32'hFFFF_EC78);
      check_eq("R7 minimum sign bit", {31'b0, d[31]}, 32'h1);

      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end
endmodule